// File: doc/BRIEF.md
# Multi-Queue Read Port Selector

This block is the read side of a device that holds four queues. Up to eight such devices can share one read address bus. A 6-bit read address is split into three fields: a device field, a null-queue bit and a queue index. A qualified clock edge loads that address as the active read selection.

The output register follows a fixed first-word-fall-through timing when the selection changes:

- On the first edge after the select, the old queue delivers one more word.
- On the second edge, the new queue's head word appears.
- Both of these transfers happen whatever the read enable is doing.

Outside that two-edge window, reads happen only when read enable is asserted. An active-high not-valid flag travels with the data word. An output-drive signal gives the bus release behaviour of master and slave devices.

Each queue is a small register array. A minimal write port exists so the arrays can be filled.

Top module: `rqp_read_port`

## Requirements
- R1: Read address fields: bits [1:0] give the queue index, bit [2] set means the null queue, and bits [5:3] must equal `dev_id` for this device to be selected.
- R2: A selection is taken on a rising edge only when `rd_addr_en` is 1, `cfg_done` is 1 and `flag_strobe` is 0. Otherwise the current selection stays unchanged.
- R3: On the first edge after a selection, the next word of the previously selected queue is popped into `dout`, with `out_valid_n` low, whatever `ren_n` is.
- R4: On the second edge after a selection, the head word of the newly selected queue is popped into `dout`, with `out_valid_n` low, whatever `ren_n` is.
- R5: Outside the two-edge switch window, an edge with `ren_n` low pops the head of the selected queue into `dout` and drives `out_valid_n` low. An edge with `ren_n` high leaves `dout` and `out_valid_n` unchanged.
- R6: Any read attempt, forced or enabled, on an empty queue or with no queue selected sets `out_valid_n` high. In that case `dout` keeps its value and nothing is popped.
- R7: Selecting the null queue with a matching device field leaves no queue selected. No word is popped from any queue while that selection stands.
- R8: A selection whose device field differs from `dev_id` deselects the device. A slave device then holds `dout_drive` low.
- R9: With `is_master` = 1, `dout_drive` equals the inverse of `oe_n`. With `is_master` = 0, `dout_drive` is 1 only while the device is selected and `oe_n` is 0.
- R10: Reset (`rst` high, synchronous) empties every queue, clears the selection, sets `dout` to 0 and sets `out_valid_n` to 1.
- R11: `wr_en` appends `wr_data` to queue `wr_q` unless that queue already holds `DEPTH` words. A write to a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration finished; selections allowed |
| is_master | input | 1 | 1 = master device, 0 = slave |
| dev_id | input | 3 | This device's identifier |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | 6 | Read selection address |
| rd_addr_en | input | 1 | Qualifies `rd_addr` as a selection |
| flag_strobe | input | 1 | Flag-bus strobe; blocks a selection in the same cycle |
| ren_n | input | 1 | Read enable, active low |
| wr_en | input | 1 | Write strobe for filling queues |
| wr_q | input | 2 | Queue written |
| wr_data | input | 18 | Word written |
| dout | output | 18 | Registered output word |
| out_valid_n | output | 1 | 1 = `dout` not valid |
| dout_drive | output | 1 | 1 = the device drives the output bus |

## Verification
`dout` and `out_valid_n` are registered, so each is due one edge after the cycle that caused it. After a selection, the old queue's word is due at edge one and the new queue's word at edge two. `dout_drive` is combinational from `oe_n` and the registered device-selected state, so it follows `oe_n` within the same cycle.

The driver works out these values with its own queue model at the falling edge, just before the rising edge that produces them. The monitor compares them 5 ns after that rising edge. Each expected item is therefore matched with exactly the edge that owns it.

// File: rtl/rqp_pkg.sv
package rqp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_NEW  = 2'd1,
    PH_OLD  = 2'd2
  } sw_phase_t;
endpackage

// File: rtl/rqp_addr_decode.sv
module rqp_addr_decode #(
  parameter int NUM_Q = 4,
  parameter int DEV_W = 3,
  localparam int QIDX_W = $clog2(NUM_Q),
  localparam int ADDR_W = DEV_W + 1 + QIDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DEV_W-1:0]  dev_id,
  output logic [QIDX_W-1:0] q_idx,
  output logic              is_null,
  output logic              dev_match
);
  assign q_idx     = addr[QIDX_W-1:0];
  assign is_null   = addr[QIDX_W];
  assign dev_match = (addr[ADDR_W-1 -: DEV_W] == dev_id);
endmodule

// File: rtl/rqp_queue_bank.sv
module rqp_queue_bank #(
  parameter int NUM_Q  = 4,
  parameter int DATA_W = 18,
  parameter int DEPTH  = 8,
  localparam int QIDX_W = $clog2(NUM_Q),
  localparam int AW     = $clog2(DEPTH),
  localparam int PTR_W  = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [QIDX_W-1:0]       wr_q,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    pop_en,
  input  logic [QIDX_W-1:0]       pop_q,
  output logic [NUM_Q*DATA_W-1:0] head_flat,
  output logic [NUM_Q-1:0]        empty
);
  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic              full, do_wr, do_rd;

    assign full     = ((wp - rp) == PTR_W'(DEPTH));
    assign empty[g] = (wp == rp);
    assign do_wr    = wr_en && (wr_q == QIDX_W'(g)) && !full;
    assign do_rd    = pop_en && (pop_q == QIDX_W'(g)) && !empty[g];

    always_ff @(posedge clk) begin
      if (do_wr) mem[wp[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (do_wr) wp <= wp + 1'b1;
        if (do_rd) rp <= rp + 1'b1;
      end
    end

    assign head_flat[g*DATA_W +: DATA_W] = mem[rp[AW-1:0]];
  end
endmodule

// File: rtl/rqp_read_ctrl.sv
module rqp_read_ctrl #(
  parameter int NUM_Q  = 4,
  parameter int DATA_W = 18,
  localparam int QIDX_W = $clog2(NUM_Q)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_done,
  input  logic                    addr_en,
  input  logic                    flag_strobe,
  input  logic                    ren_n,
  input  logic                    is_master,
  input  logic                    oe_n,
  input  logic [QIDX_W-1:0]       dec_q,
  input  logic                    dec_null,
  input  logic                    dec_match,
  input  logic [NUM_Q-1:0]        empty,
  input  logic [NUM_Q*DATA_W-1:0] head_flat,
  output logic                    pop_en,
  output logic [QIDX_W-1:0]       pop_q,
  output logic [DATA_W-1:0]       dout,
  output logic                    out_valid_n,
  output logic                    dout_drive,
  output rqp_pkg::sw_phase_t      phase,
  output logic                    cur_valid,
  output logic [QIDX_W-1:0]       cur_q
);
  import rqp_pkg::*;

  logic              sel_ok;
  logic [QIDX_W-1:0] prev_q, src_q;
  logic              prev_valid, src_valid, take, hit, dev_sel;

  assign sel_ok = cfg_done && addr_en && !flag_strobe;

  always_comb begin
    unique case (phase)
      PH_OLD: begin src_q = prev_q; src_valid = prev_valid; take = 1'b1;   end
      PH_NEW: begin src_q = cur_q;  src_valid = cur_valid;  take = 1'b1;   end
      default: begin src_q = cur_q; src_valid = cur_valid;  take = !ren_n; end
    endcase
  end

  assign hit    = take && src_valid && !empty[src_q];
  assign pop_en = hit;
  assign pop_q  = src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      cur_q       <= '0;
      cur_valid   <= 1'b0;
      prev_q      <= '0;
      prev_valid  <= 1'b0;
      dev_sel     <= 1'b0;
      dout        <= '0;
      out_valid_n <= 1'b1;
    end else begin
      if (take) begin
        if (hit) begin
          dout        <= head_flat[src_q*DATA_W +: DATA_W];
          out_valid_n <= 1'b0;
        end else begin
          out_valid_n <= 1'b1;
        end
      end
      if (sel_ok) begin
        phase      <= PH_OLD;
        prev_q     <= cur_q;
        prev_valid <= cur_valid;
        cur_q      <= dec_q;
        cur_valid  <= dec_match && !dec_null;
        dev_sel    <= dec_match;
      end else if (phase == PH_OLD) begin
        phase <= PH_NEW;
      end else begin
        phase <= PH_IDLE;
      end
    end
  end

  assign dout_drive = !oe_n && (is_master || dev_sel);
endmodule

// File: rtl/rqp_read_port.sv
module rqp_read_port #(
  parameter int NUM_Q  = 4,
  parameter int DEV_W  = 3,
  parameter int DATA_W = 18,
  parameter int DEPTH  = 8,
  localparam int QIDX_W = $clog2(NUM_Q),
  localparam int ADDR_W = DEV_W + 1 + QIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_done,
  input  logic              is_master,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_addr_en,
  input  logic              flag_strobe,
  input  logic              ren_n,
  input  logic              wr_en,
  input  logic [QIDX_W-1:0] wr_q,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              out_valid_n,
  output logic              dout_drive
);
  logic [QIDX_W-1:0]       dec_q, pop_q, cur_q;
  logic                    dec_null, dec_match, pop_en, cur_valid;
  logic [NUM_Q-1:0]        empty;
  logic [NUM_Q*DATA_W-1:0] head_flat;
  rqp_pkg::sw_phase_t      phase;

  rqp_addr_decode #(.NUM_Q(NUM_Q), .DEV_W(DEV_W)) u_dec (
    .addr(rd_addr), .dev_id(dev_id),
    .q_idx(dec_q), .is_null(dec_null), .dev_match(dec_match)
  );

  rqp_queue_bank #(.NUM_Q(NUM_Q), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .pop_en(pop_en), .pop_q(pop_q),
    .head_flat(head_flat), .empty(empty)
  );

  rqp_read_ctrl #(.NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .addr_en(rd_addr_en),
    .flag_strobe(flag_strobe), .ren_n(ren_n), .is_master(is_master), .oe_n(oe_n),
    .dec_q(dec_q), .dec_null(dec_null), .dec_match(dec_match),
    .empty(empty), .head_flat(head_flat),
    .pop_en(pop_en), .pop_q(pop_q), .dout(dout), .out_valid_n(out_valid_n),
    .dout_drive(dout_drive), .phase(phase), .cur_valid(cur_valid), .cur_q(cur_q)
  );
endmodule

// File: rtl/rqp_read_port_chk.sv
module rqp_read_port_chk #(
  parameter int NUM_Q  = 4,
  parameter int DEV_W  = 3,
  parameter int DATA_W = 18,
  localparam int QIDX_W = $clog2(NUM_Q),
  localparam int ADDR_W = DEV_W + 1 + QIDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_done,
  input logic              rd_addr_en,
  input logic              flag_strobe,
  input logic              ren_n,
  input logic              is_master,
  input logic [DEV_W-1:0]  dev_id,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] dout,
  input logic              out_valid_n,
  input logic              dout_drive,
  input logic [1:0]        phase,
  input logic              cur_valid,
  input logic [QIDX_W-1:0] cur_q
);
  logic accept;
  assign accept = cfg_done && rd_addr_en && !flag_strobe;

  AST_NO_SEL_BEFORE_CFG: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> ($stable(cur_q) && $stable(cur_valid))); // R2
  AST_SWITCH_OPENS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (phase == 2'd2)); // R3
  AST_NEW_FOLLOWS_OLD: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !accept) |=> (phase == 2'd1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && ren_n && !accept) |=> ($stable(dout) && $stable(out_valid_n))); // R5
  AST_NO_QUEUE_INVALID: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && !ren_n && !cur_valid) |=> out_valid_n); // R6
  AST_SLAVE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!is_master && accept && rd_addr[ADDR_W-1 -: DEV_W] != dev_id)
      |=> (is_master || !dout_drive)); // R8
endmodule

bind rqp_read_port rqp_read_port_chk #(.NUM_Q(NUM_Q), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_done(cfg_done), .rd_addr_en(rd_addr_en),
  .flag_strobe(flag_strobe), .ren_n(ren_n), .is_master(is_master), .dev_id(dev_id),
  .rd_addr(rd_addr), .dout(dout), .out_valid_n(out_valid_n), .dout_drive(dout_drive),
  .phase(phase), .cur_valid(cur_valid), .cur_q(cur_q)
);

// File: tb/sim_rqp_read_port.sv
module sim_rqp_read_port;
  localparam int DEPTH = 8;
  localparam logic [2:0] MY_ID = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1, cfg_done = 1'b0, is_master = 1'b1, oe_n = 1'b0;
  logic [5:0] rd_addr = '0;
  logic rd_addr_en = 1'b0, flag_strobe = 1'b0, ren_n = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_q = '0;
  logic [17:0] wr_data = '0;
  logic [17:0] dout;
  logic out_valid_n, dout_drive;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rqp_read_port u0 (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .is_master(is_master), .dev_id(MY_ID),
    .oe_n(oe_n), .rd_addr(rd_addr), .rd_addr_en(rd_addr_en), .flag_strobe(flag_strobe),
    .ren_n(ren_n), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .dout(dout), .out_valid_n(out_valid_n), .dout_drive(dout_drive)
  );

  // reference model state
  logic [17:0] mq [4][$];
  logic [1:0] m_cur_q = 0, m_prev_q = 0;
  bit m_cur_v = 0, m_prev_v = 0, m_dev = 0;
  int m_phase = 0;
  logic [17:0] m_dout = 0;
  bit m_ovn = 1;

  // scoreboard
  logic [17:0] sb_dout [$];
  bit sb_ovn [$], sb_drv [$];
  string sb_tag [$];

  task automatic cyc(string tag);
    bit take, sv, ok;
    logic [1:0] sq;
    if (rst) begin
      for (int i = 0; i < 4; i++) mq[i].delete();
      m_cur_v = 0; m_prev_v = 0; m_dev = 0; m_phase = 0; m_dout = 0; m_ovn = 1;
      m_cur_q = 0; m_prev_q = 0;
    end else begin
      if (m_phase == 2) begin sq = m_prev_q; sv = m_prev_v; take = 1; end
      else if (m_phase == 1) begin sq = m_cur_q; sv = m_cur_v; take = 1; end
      else begin sq = m_cur_q; sv = m_cur_v; take = !ren_n; end
      if (take) begin
        if (sv && mq[sq].size() > 0) begin m_dout = mq[sq].pop_front(); m_ovn = 0; end
        else m_ovn = 1;
      end
      if (wr_en && mq[wr_q].size() < DEPTH) mq[wr_q].push_back(wr_data);
      ok = cfg_done && rd_addr_en && !flag_strobe;
      if (ok) begin
        m_phase = 2; m_prev_q = m_cur_q; m_prev_v = m_cur_v;
        m_cur_q = rd_addr[1:0];
        m_dev = (rd_addr[5:3] == MY_ID);
        m_cur_v = m_dev && !rd_addr[2];
      end else m_phase = (m_phase == 2) ? 1 : 0;
    end
    sb_dout.push_back(m_dout);
    sb_ovn.push_back(m_ovn);
    sb_drv.push_back(!oe_n && (is_master || m_dev));
    sb_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic chk(string tag, string what, logic [17:0] act, logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (sb_tag.size() > 0) begin
        string t;
        t = sb_tag.pop_front();
        chk(t, "dout", dout, sb_dout.pop_front());
        chk(t, "out_valid_n", {17'b0, out_valid_n}, {17'b0, sb_ovn.pop_front()});
        chk(t, "dout_drive", {17'b0, dout_drive}, {17'b0, sb_drv.pop_front()});
      end
    end
  end

  task automatic sel(logic [2:0] dev, bit nul, logic [1:0] q, string tag);
    rd_addr = {dev, nul, q}; rd_addr_en = 1;
    cyc(tag);
    rd_addr_en = 0;
  endtask

  task automatic wr(logic [1:0] q, logic [17:0] d);
    wr_en = 1; wr_q = q; wr_data = d;
    cyc("R11");
    wr_en = 0;
  endtask

  initial begin : driver
    @(negedge clk);
    cyc("R10"); cyc("R10");
    rst = 0;
    cyc("R10");
    for (int i = 0; i < 5; i++) wr(2'd0, 18'h100 + 18'(i));
    for (int i = 0; i < 3; i++) wr(2'd1, 18'h200 + 18'(i));
    wr(2'd2, 18'h300);
    for (int i = 0; i < 9; i++) wr(2'd3, 18'h3A0 + 18'(i));   // ninth is dropped (R11)
    // selection blocked before configuration (R2)
    ren_n = 0;
    sel(MY_ID, 0, 2'd0, "R2"); cyc("R2"); cyc("R2"); cyc("R2");
    cfg_done = 1;
    flag_strobe = 1;
    sel(MY_ID, 0, 2'd0, "R2");
    flag_strobe = 0;
    cyc("R2"); cyc("R2");
    // first select, read enable held off (R3, R4)
    ren_n = 1;
    sel(MY_ID, 0, 2'd0, "R3"); cyc("R3"); cyc("R4");
    cyc("R5");
    ren_n = 0; cyc("R5"); cyc("R5");
    // switch to queue 1 (R3, R4)
    ren_n = 1;
    sel(MY_ID, 0, 2'd1, "R3"); cyc("R3"); cyc("R4");
    ren_n = 0; cyc("R5"); cyc("R5"); cyc("R6"); cyc("R6");
    // queue index field (R1)
    ren_n = 1;
    sel(MY_ID, 0, 2'd2, "R1"); cyc("R6"); cyc("R1");
    // null queue (R7)
    sel(MY_ID, 1, 2'd0, "R7"); cyc("R7"); cyc("R7");
    ren_n = 0; cyc("R7"); cyc("R7");
    ren_n = 1;
    sel(MY_ID, 0, 2'd0, "R7"); cyc("R7"); cyc("R7");
    // output drive for master and slave (R9, R8)
    oe_n = 1; cyc("R9");
    oe_n = 0; cyc("R9");
    is_master = 0; cyc("R9");
    oe_n = 1; cyc("R9");
    oe_n = 0;
    sel(3'd2, 0, 2'd0, "R8"); cyc("R8"); cyc("R8");
    oe_n = 1; cyc("R8");
    oe_n = 0;
    sel(MY_ID, 0, 2'd3, "R9"); cyc("R9"); cyc("R11");
    ren_n = 0;
    for (int i = 0; i < 8; i++) cyc("R11");
    ren_n = 1;
    cyc("R11");
    cyc("R11");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule